// File: doc/BRIEF.md
# Serial Line Transmitter with Frame Formatting

This block turns bytes written by a host into asynchronous serial frames. A byte is written into a one-entry holding register; when the line is idle, or as soon as the frame in flight has sent its last stop pulse, the byte moves into a shift register. It then goes out as a low start bit, 5 to 8 data bits least significant bit first, an optional parity bit and one, one-and-a-half or two high stop bits. A separate break control holds the line low whenever it is set.

Everything runs on the system clock. Bit timing comes from a single-cycle enable, `baud_en`, that pulses at sixteen times the bit rate. Every bit lasts `OSR` such pulses, and a half stop bit lasts `OSR/2` of them. Two status outputs tell the host when it may write another byte and when the line has fully drained. The frame format is captured when a byte enters the shift register. Changing the format while a frame is being sent therefore affects only later frames. Break is the exception: it acts at once.

Top module: `uart_tx_fmt`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it is released with no write, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A frame starts with a 0 start bit, followed by the data bits least significant bit first. The number of data bits is set by `line_ctrl[1:0]`: 00 selects 5, 01 selects 6, 10 selects 7 and 11 selects 8. Each bit lasts exactly `OSR` pulses of `baud_en`, and the frame does not advance on cycles where `baud_en` is low. Data bits beyond the word length are not sent.
- R3: When `line_ctrl[2]` is 0, the stop level (1) lasts `OSR` pulses. When it is 1, the stop level lasts `OSR*3/2` pulses for 5-bit words and `2*OSR` pulses for 6-, 7- and 8-bit words.
- R4: When `line_ctrl[3]` is 1, a parity bit of `OSR` pulses is sent between the last data bit and the stop bits. With `line_ctrl[4]` = 1 the number of ones in the data plus parity is even; with 0 it is odd. When `line_ctrl[3]` is 0, no parity bit is sent.
- R5: When `line_ctrl[5]` is 1 and parity is enabled, the parity bit is the inverse of `line_ctrl[4]`: 0 when even is selected and 1 when odd is selected, whatever the data.
- R6: While `line_ctrl[6]` is 1, `txd` is 0 in the same cycle, including during a frame. Frame timing continues underneath. When the bit is cleared, `txd` shows the normal line level again.
- R7: A write (`hold_wr` high at a clock edge) makes `hold_empty` 0 from that edge on. `hold_empty` returns to 1 at the edge where the byte moves into the shift register.
- R8: With the line idle, a held byte moves into the shift register at the next clock edge, and its start bit begins there. With a frame in progress, the held byte moves at the edge that consumes the last stop pulse, so the next start bit follows with no idle gap.
- R9: `tx_empty` is 1 only when no byte is held and no frame is in progress. It rises at the edge that consumes the final stop pulse when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_en | input | 1 | Single-cycle pulse at OSR times the bit rate |
| line_ctrl | input | 7 | Frame format: [1:0] length, [2] long stop, [3] parity enable, [4] even, [5] stick, [6] break |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output line, idle high |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding and shift registers both empty |

## Verification
The main check sweeps all 64 combinations of word length, stop length, parity enable, parity sense and stick parity. For each combination, two bytes are sent back to back and the line is recorded once per `baud_en` pulse. The recorded trace is compared, pulse by pulse, with a frame built arithmetically in the bench. Each data byte is derived from the configuration index, so across the sweep the parity bit takes both values. This separates a wrong word-length mask from a wrong parity sense or a stick-parity fault. Because the second frame follows directly, the length of the stop run can be measured exactly, which separates 1, 1.5 and 2 stop bits and would show any gap between frames. Separate directed tests check the exact edge timing of the two status flags after a write and show that break forces the line low both when idle and in the middle of a frame.

// File: rtl/uart_tx_pkg.sv
// Shared types for the serial transmitter.
// Assumes the format word layout is fixed by the line control input bits [5:0].
package uart_tx_pkg;

    localparam int TX_WORD_MAX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    // Frame format, packed so that it maps bit for bit onto line_ctrl[5:0].
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] wlen;
    } tx_fmt_t;

endpackage

// File: rtl/uart_tx_hold.sv
// One-entry holding register in front of the shift register.
// Assumes a write and a take in the same cycle leave the new byte held.
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [TX_WORD_MAX-1:0] wdata,
    input  logic                   take,
    output logic                   full,
    output logic [TX_WORD_MAX-1:0] data
);

    // Track occupancy and capture the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr) begin
                full <= 1'b1;
                data <= wdata;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> full);

    assert_take_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr) |=> !full);

endmodule

// File: rtl/uart_tx_frame.sv
// Frame sequencer: start, data (LSB first), optional parity and stop bits.
// Each bit lasts OSR baud_en pulses; the format is latched when a byte loads.
// Assumes baud_en is a single-cycle pulse and OSR is even and at least 4.
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   baud_en,
    input  tx_fmt_t                fmt,
    input  logic                   pend,
    input  logic [TX_WORD_MAX-1:0] pend_data,
    output logic                   take,
    output logic                   line,
    output logic                   busy
);

    localparam int CNT_W = $clog2(2 * OSR);
    localparam int IDX_W = $clog2(TX_WORD_MAX);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] STOP_1   = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] STOP_15  = CNT_W'(OSR + OSR / 2 - 1);
    localparam logic [CNT_W-1:0] STOP_2   = CNT_W'(2 * OSR - 1);

    tx_state_e              state;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       stop_last;
    logic [TX_WORD_MAX-1:0] shreg;
    logic [IDX_W-1:0]       bit_idx;
    logic [IDX_W-1:0]       last_idx;
    logic                   par_q;
    logic                   par_en_q;
    logic                   bit_end;
    logic                   stop_done;

    // Parity over the active data bits, with stick override.
    function automatic logic par_calc(input logic [TX_WORD_MAX-1:0] d, input tx_fmt_t f);
        logic x;
        x = 1'b0;
        for (int i = 0; i < TX_WORD_MAX; i++) begin
            if (i < 5 + int'(f.wlen)) x ^= d[i];
        end
        if (f.stick) return ~f.even;
        return f.even ? x : ~x;
    endfunction

    // Pulse and transfer conditions.
    always_comb begin
        bit_end   = baud_en && (cnt == BIT_LAST);
        stop_done = (state == ST_STOP) && baud_en && (cnt == stop_last);
        take      = pend && ((state == ST_IDLE) || stop_done);
        busy      = (state != ST_IDLE);
    end

    // Line level for the current state.
    always_comb begin
        unique case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    // Load a byte with its format, then step through the frame on baud pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            stop_last <= STOP_1;
            shreg     <= '0;
            bit_idx   <= '0;
            last_idx  <= '0;
            par_q     <= 1'b0;
            par_en_q  <= 1'b0;
        end else if (take) begin
            state     <= ST_START;
            cnt       <= '0;
            shreg     <= pend_data;
            bit_idx   <= '0;
            last_idx  <= IDX_W'(4) + IDX_W'(fmt.wlen);
            par_q     <= par_calc(pend_data, fmt);
            par_en_q  <= fmt.par_en;
            stop_last <= !fmt.stop_long ? STOP_1 : (fmt.wlen == 2'b00 ? STOP_15 : STOP_2);
        end else if (baud_en) begin
            unique case (state)
                ST_START: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) state <= ST_DATA;
                end
                ST_DATA: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        if (bit_idx == last_idx) state <= par_en_q ? ST_PAR : ST_STOP;
                        else bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_PAR: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) state <= ST_STOP;
                end
                ST_STOP: begin
                    cnt <= stop_done ? '0 : cnt + 1'b1;
                    if (stop_done) state <= ST_IDLE;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assert_hold_without_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !baud_en) |=> ($stable(cnt) && $stable(state)));

    assert_stop_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> (cnt <= stop_last));

    assert_start_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state == ST_START && cnt == '0));

endmodule

// File: rtl/uart_tx_fmt.sv
// Serial transmitter top: holding register, frame sequencer and break gate.
// Assumes baud_en pulses at OSR times the bit rate, one clock wide.
module uart_tx_fmt
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_en,
    input  logic [6:0] line_ctrl,
    input  logic       hold_wr,
    input  logic [7:0] hold_data,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);

    tx_fmt_t                fmt;
    logic                   full;
    logic [TX_WORD_MAX-1:0] held;
    logic                   take;
    logic                   line;
    logic                   busy;

    // Decode the format field and combine status.
    always_comb begin
        fmt        = tx_fmt_t'(line_ctrl[5:0]);
        txd        = line & ~line_ctrl[6];
        hold_empty = ~full;
        tx_empty   = ~full & ~busy;
    end

    uart_tx_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (hold_wr),
        .wdata (hold_data),
        .take  (take),
        .full  (full),
        .data  (held)
    );

    uart_tx_frame #(.OSR(OSR)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_en   (baud_en),
        .fmt       (fmt),
        .pend      (full),
        .pend_data (held),
        .take      (take),
        .line      (line),
        .busy      (busy)
    );

    assert_txe_needs_thre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    assert_idle_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !busy && !hold_wr) |=> hold_empty);

endmodule

// File: tb/tb_uart_tx_fmt.sv
module tb_uart_tx_fmt;
    localparam int OSR = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_en = 1'b0;
    logic [6:0] line_ctrl = '0;
    logic       hold_wr = 1'b0;
    logic [7:0] hold_data = '0;
    wire        txd, hold_empty, tx_empty;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   cap_on = 1'b0;
    bit   baud_run = 1'b0;
    int   ns = 0;
    int   ne = 0;
    logic samp [0:1023];
    logic expv [0:1023];

    always #5 clk = ~clk;

    uart_tx_fmt #(.OSR(OSR)) dut (
        .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .line_ctrl(line_ctrl),
        .hold_wr(hold_wr), .hold_data(hold_data), .txd(txd),
        .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    // baud pulse every second cycle, changed just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (baud_run) baud_en = ~baud_en;
            else baud_en = 1'b0;
        end
    end

    // record the line once per baud pulse
    initial begin
        forever begin
            @(negedge clk);
            if (cap_on && baud_en && ns < 1024) begin
                samp[ns] = txd;
                ns++;
            end
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    task automatic check(input string tag, input int act, input int expct);
        n_chk++;
        if (act !== expct) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expct);
        end
    endtask

    task automatic push(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            expv[ne] = v;
            ne++;
        end
    endtask

    task automatic add_frame(input logic [7:0] d, input logic [5:0] c,
                             output int e_data, output int e_par);
        int   wl;
        int   ones;
        int   stop;
        logic p;
        wl = 5 + int'(c[1:0]);
        ones = 0;
        push(1'b0, OSR);
        for (int i = 0; i < wl; i++) begin
            push(d[i], OSR);
            ones += int'(d[i]);
        end
        e_data = ne;
        if (c[3]) begin
            if (c[5]) p = ~c[4];
            else if (c[4]) p = ((ones % 2) == 1);
            else p = ((ones % 2) == 0);
            push(p, OSR);
        end
        e_par = ne;
        if (!c[2]) stop = OSR;
        else if (wl == 5) stop = OSR + OSR / 2;
        else stop = 2 * OSR;
        push(1'b1, stop);
    endtask

    function automatic int mism(input int s, input int from, input int to);
        int m;
        m = 0;
        for (int k = from; k < to; k++) begin
            if (s + k >= ns) m++;
            else if (samp[s + k] !== expv[k]) m++;
        end
        return m;
    endfunction

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        hold_wr = 1'b1;
        hold_data = d;
        @(negedge clk);
        hold_wr = 1'b0;
    endtask

    task automatic wait_flag(input bit which);
        for (int i = 0; i < 4000; i++) begin
            if ((which ? tx_empty : hold_empty) == 1'b1) break;
            @(negedge clk);
        end
    endtask

    initial begin
        int   s;
        int   ea_d, ea_p, eb_d, eb_p, a_end;
        logic [7:0] a, b;
        int   lows;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 txd in reset", int'(txd), 1);
        check("R1 hold_empty in reset", int'(hold_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 txd after reset", int'(txd), 1);
        check("R1 tx_empty after reset", int'(tx_empty), 1);
        baud_run = 1'b1;
        repeat (4) @(negedge clk);

        // Sweep all frame formats, two frames back to back
        for (int c = 0; c < 64; c++) begin
            a = 8'((c * 37 + 5) & 8'hFF);
            b = ~a ^ 8'(c);
            line_ctrl = 7'(c);
            ns = 0;
            ne = 0;
            add_frame(a, 6'(c), ea_d, ea_p);
            a_end = ne;
            add_frame(b, 6'(c), eb_d, eb_p);
            cap_on = 1'b1;
            write_byte(a);
            wait_flag(1'b0);
            write_byte(b);
            wait_flag(1'b1);
            @(negedge clk);
            cap_on = 1'b0;
            s = 0;
            while (s < ns && samp[s] !== 1'b0) s++;
            check($sformatf("R2 start/data cfg=%0d", c), mism(s, 0, ea_d), 0);
            if (c[5] && c[3])
                check($sformatf("R5 stick parity cfg=%0d", c), mism(s, ea_d, ea_p), 0);
            else
                check($sformatf("R4 parity cfg=%0d", c), mism(s, ea_d, ea_p), 0);
            check($sformatf("R3 stop length cfg=%0d", c), mism(s, ea_p, a_end), 0);
            check($sformatf("R8 back-to-back frame cfg=%0d", c), mism(s, a_end, ne), 0);
            repeat (3) @(negedge clk);
        end

        // R7 / R9: status timing around a write on an idle line
        line_ctrl = 7'b0000011;
        @(negedge clk);
        hold_wr = 1'b1;
        hold_data = 8'hA5;
        @(negedge clk);
        hold_wr = 1'b0;
        check("R7 hold_empty low after write", int'(hold_empty), 0);
        check("R9 tx_empty low after write", int'(tx_empty), 0);
        @(negedge clk);
        check("R7 hold_empty high after transfer", int'(hold_empty), 1);
        check("R9 tx_empty low while sending", int'(tx_empty), 0);
        wait_flag(1'b1);
        check("R9 tx_empty after frame", int'(tx_empty), 1);

        // R6: break while idle
        @(negedge clk);
        line_ctrl[6] = 1'b1;
        #1;
        check("R6 break idle txd", int'(txd), 0);
        @(negedge clk);
        line_ctrl[6] = 1'b0;
        #1;
        check("R6 break released idle", int'(txd), 1);

        // R6: break through a whole frame; frame still completes
        @(negedge clk);
        line_ctrl = 7'b1000011;
        write_byte(8'hFF);
        lows = 0;
        for (int i = 0; i < 4000; i++) begin
            if (tx_empty) break;
            if (txd === 1'b1) lows++;
            @(negedge clk);
        end
        check("R6 break high samples during frame", lows, 0);
        check("R6 frame completes under break", int'(tx_empty), 1);
        line_ctrl[6] = 1'b0;
        #1;
        check("R6 line high after break clears", int'(txd), 1);

        report();
        $finish;
    end
endmodule